// File: doc/BRIEF.md
# CPU Endpoint Transmit FIFO Write Port

This block gives a processor a byte-wide path into the transmit buffers of five endpoints: a default endpoint 0 and four further endpoints A, B, C and D. The processor works through a small register bus with a 3-bit offset, write and read strobes, and 8-bit write and read data. It sets an access enable, chooses an endpoint through a select register, and then writes bytes one by one to a data window. Each write to the window pushes one byte into the buffer of the chosen endpoint.

The chosen endpoint follows a fixed priority. When several select bits are set, the highest one wins. When no select bit is set, endpoint 0 is used. The free space of the chosen buffer can always be read back, along with a sticky flag that records a byte lost to a full buffer. Each endpoint buffer is a small 16-entry FIFO. Each has a drain port that stands in for the rest of the endpoint logic, which empties the buffer.

Top module: `cpu_ep_fill_port`

## Requirements
- R1: After reset both access enable flags are 0, the endpoint select is 0, the overflow flag is 0 and every FIFO is empty, so offset 4 reads 16 and offset 3 reads 0.
- R2: The access enable register at offset 0 stores a write flag in bit 1 and a read flag in bit 0; bits 7 to 2 always read as 0.
- R3: The endpoint select register at offset 1 stores bits 3 to 0 (bit 0 = endpoint A, bit 1 = B, bit 2 = C, bit 3 = D); bits 7 to 4 read as 0.
- R4: When several select bits are 1, the endpoint of the highest set bit is the target for window writes and for the free-space readout.
- R5: When all select bits are 0, endpoint 0 is the target.
- R6: With the write flag at 1, a write to the data window at offset 2 pushes the byte into the target FIFO, and the drain port returns the bytes in the order they were written.
- R7: With the write flag at 0, a write to the data window is ignored: no FIFO count or content changes.
- R8: A window write to a full target FIFO is dropped and sets a sticky overflow flag at bit 7 of offset 3; a read of offset 3 returns the flag and clears it.
- R9: Offset 4 reads the low byte and offset 3 bits 6 to 0 read the high bits of 16 minus the target FIFO's fill count, updated in the cycle after each push or drain.
- R10: Read data appears on the cycle after the read strobe and holds until the next read; the data window and offsets 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| drain_pop | input | 5 | Per-endpoint drain request (bit 0 = endpoint 0, bits 1 to 4 = A to D) |
| drain_data | output | 40 | Head byte of each endpoint FIFO, 8 bits per endpoint, endpoint 0 lowest |
| drain_valid | output | 5 | Per-endpoint FIFO not empty |

## Verification
On every cycle the assertions check that exactly one endpoint is the target, that no FIFO count ever exceeds its depth or moves on a full push, that a disabled window write leaves every count unchanged, that a push to a full buffer leaves the overflow flag set, and that read data holds between read strobes. The priority order across select patterns, the byte order seen at the drain ports, the clear-on-read of the overflow flag and the exact free-space values can only be shown by the bench. It does so with directed corner cases and a seeded random mix of register accesses and drains, compared against a reference model.

// File: rtl/ep_win_pkg.sv
package ep_win_pkg;
    // register offsets; the fill-count pair is split high/low
    localparam logic [2:0] OFF_ENABLE  = 3'd0;
    localparam logic [2:0] OFF_SELECT  = 3'd1;
    localparam logic [2:0] OFF_WINDOW  = 3'd2;
    localparam logic [2:0] OFF_FREE_HI = 3'd3;
    localparam logic [2:0] OFF_FREE_LO = 3'd4;

    // endpoint 0 plus one endpoint per select bit
    localparam int SEL_BITS = 4;
    localparam int EP_COUNT = SEL_BITS + 1;

    // bit positions inside the access enable register
    localparam int BIT_WR_FLAG = 1;
    localparam int BIT_RD_FLAG = 0;
endpackage

// File: rtl/ep_byte_fifo.sv
module ep_byte_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic [DATA_W-1:0]               push_data,
    input  logic                            pop,
    output logic [DATA_W-1:0]               head_data,
    output logic                            full,
    output logic                            empty,
    output logic [$clog2(DEPTH+1)-1:0]      count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] fill;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.fill != CNT_W'(DEPTH));
        do_pop  = pop && (st_q.fill != '0);
        if (do_push) begin
            st_d.wr_ptr = (st_q.wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd_ptr + 1'b1;
        end
        if (do_push && !do_pop) begin
            st_d.fill = st_q.fill + 1'b1;
        end else if (do_pop && !do_push) begin
            st_d.fill = st_q.fill - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr_ptr] <= push_data;
        end
    end

    assign head_data = mem_q[st_q.rd_ptr];
    assign full      = (st_q.fill == CNT_W'(DEPTH));
    assign empty     = (st_q.fill == '0);
    assign count     = st_q.fill;

    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= CNT_W'(DEPTH));

    // R8
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(st_q.fill));
endmodule

// File: rtl/ep_target_pick.sv
module ep_target_pick #(
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    output logic [SEL_W:0]   target
);
    // target[0] is the default endpoint, target[k+1] follows sel[k];
    // later loop passes overwrite earlier ones, so the highest bit wins
    always_comb begin
        target    = '0;
        target[0] = 1'b1;
        for (int k = 0; k < SEL_W; k++) begin
            if (sel[k]) begin
                target        = '0;
                target[k + 1] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpu_ep_fill_port.sv
module cpu_ep_fill_port
    import ep_win_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DATA_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   bus_addr,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [EP_COUNT-1:0]          drain_pop,
    output logic [EP_COUNT*DATA_W-1:0]   drain_data,
    output logic [EP_COUNT-1:0]          drain_valid
);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int FREE_W = 2 * DATA_W - 1;

    typedef struct packed {
        logic                wr_flag;
        logic                rd_flag;
        logic [SEL_BITS-1:0] sel;
        logic                ovf;
        logic [DATA_W-1:0]   rdata;
    } port_regs_t;

    port_regs_t regs_d, regs_q;

    logic [EP_COUNT-1:0]            target;
    logic [EP_COUNT-1:0]            full_vec;
    logic [EP_COUNT-1:0]            empty_vec;
    logic [EP_COUNT-1:0]            push_vec;
    logic [EP_COUNT*CNT_W-1:0]      cnt_all;
    logic [CNT_W-1:0]               tgt_count;
    logic [FREE_W-1:0]              free_space;
    logic                           tgt_full;
    logic                           win_wr;
    logic                           win_push;

    ep_target_pick #(.SEL_W(SEL_BITS)) u_pick (
        .sel    (regs_q.sel),
        .target (target)
    );

    for (genvar e = 0; e < EP_COUNT; e++) begin : g_ep
        ep_byte_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_vec[e]),
            .push_data (bus_wdata),
            .pop       (drain_pop[e]),
            .head_data (drain_data[e*DATA_W +: DATA_W]),
            .full      (full_vec[e]),
            .empty     (empty_vec[e]),
            .count     (cnt_all[e*CNT_W +: CNT_W])
        );
        assign drain_valid[e] = !empty_vec[e];
    end

    // free-space readout for whichever endpoint is the target
    always_comb begin
        tgt_count = '0;
        for (int e = 0; e < EP_COUNT; e++) begin
            if (target[e]) begin
                tgt_count = cnt_all[e*CNT_W +: CNT_W];
            end
        end
        free_space = FREE_W'(CNT_W'(FIFO_DEPTH) - tgt_count);
        tgt_full   = |(full_vec & target);
    end

    always_comb begin
        regs_d   = regs_q;
        win_wr   = bus_wr && (bus_addr == OFF_WINDOW);
        win_push = win_wr && regs_q.wr_flag;
        push_vec = (win_push && !tgt_full) ? target : '0;

        if (bus_wr && (bus_addr == OFF_ENABLE)) begin
            regs_d.wr_flag = bus_wdata[BIT_WR_FLAG];
            regs_d.rd_flag = bus_wdata[BIT_RD_FLAG];
        end
        if (bus_wr && (bus_addr == OFF_SELECT)) begin
            regs_d.sel = bus_wdata[SEL_BITS-1:0];
        end

        if (bus_rd) begin
            unique case (bus_addr)
                OFF_ENABLE: begin
                    regs_d.rdata = '0;
                    regs_d.rdata[BIT_WR_FLAG] = regs_q.wr_flag;
                    regs_d.rdata[BIT_RD_FLAG] = regs_q.rd_flag;
                end
                OFF_SELECT:  regs_d.rdata = DATA_W'(regs_q.sel);
                OFF_FREE_HI: regs_d.rdata = {regs_q.ovf, free_space[FREE_W-1:DATA_W]};
                OFF_FREE_LO: regs_d.rdata = free_space[DATA_W-1:0];
                default:     regs_d.rdata = '0;
            endcase
            if (bus_addr == OFF_FREE_HI) begin
                regs_d.ovf = 1'b0;
            end
        end

        // a fresh loss wins over a clearing read in the same cycle
        if (win_push && tgt_full) begin
            regs_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata = regs_q.rdata;

    // R4
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(target) == 1);

    // R7
    disabled_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && !regs_q.wr_flag && drain_pop == '0) |=> $stable(cnt_all));

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_push && tgt_full) |=> regs_q.ovf);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/cpu_ep_fill_port_tb.sv
module cpu_ep_fill_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NEP        = 5;
    localparam int DEPTH      = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [4:0]   drain_pop = '0;
    logic [39:0]  drain_data;
    logic [4:0]   drain_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model
    int  mq [NEP][DEPTH];
    int  mh [NEP];
    int  mc [NEP];
    bit  m_wr, m_rd, m_ovf;
    bit [3:0] m_sel;

    cpu_ep_fill_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .drain_pop(drain_pop), .drain_data(drain_data), .drain_valid(drain_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int pick(bit [3:0] s);
        if (s[3]) return 4;
        if (s[2]) return 3;
        if (s[1]) return 2;
        if (s[0]) return 1;
        return 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 3'd0) begin m_wr = d[1]; m_rd = d[0]; end
        if (a == 3'd1) m_sel = d[3:0];
        if (a == 3'd2 && m_wr) begin
            int t = pick(m_sel);
            if (mc[t] < DEPTH) begin
                mq[t][(mh[t] + mc[t]) % DEPTH] = d;
                mc[t]++;
            end else begin
                m_ovf = 1'b1;
            end
        end
    endtask

    task automatic bus_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] expect_read(logic [2:0] a);
        case (a)
            3'd0: return {6'b0, m_wr, m_rd};
            3'd1: return {4'b0, m_sel};
            3'd3: return {m_ovf, 7'b0};
            3'd4: return 8'(DEPTH - mc[pick(m_sel)]);
            default: return 8'h00;
        endcase
    endfunction

    task automatic read_check(logic [2:0] a, string req);
        logic [7:0] got;
        logic [7:0] exp;
        exp = expect_read(a);
        bus_read(a, got);
        if (a == 3'd3) m_ovf = 1'b0;
        check(got == exp, req, got, exp);
    endtask

    task automatic drain(int e, string req);
        @(negedge clk);
        check(drain_valid[e] == (mc[e] > 0), req, drain_valid[e], mc[e] > 0);
        if (mc[e] > 0) begin
            check(drain_data[e*8 +: 8] == 8'(mq[e][mh[e]]), req,
                  drain_data[e*8 +: 8], mq[e][mh[e]]);
            mh[e] = (mh[e] + 1) % DEPTH;
            mc[e]--;
        end
        drain_pop[e] = 1'b1;
        @(negedge clk);
        drain_pop = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        for (int e = 0; e < NEP; e++) begin mh[e] = 0; mc[e] = 0; end
        m_wr = 0; m_rd = 0; m_ovf = 0; m_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_check(3'd0, "R1");
        read_check(3'd1, "R1");
        read_check(3'd3, "R1");
        read_check(3'd4, "R1");
        check(drain_valid == 5'b0, "R1", drain_valid, 0);

        // R2 / R3 reserved bits
        bus_write(3'd0, 8'hFF);
        read_check(3'd0, "R2");
        bus_write(3'd0, 8'h02);
        read_check(3'd0, "R2");
        bus_write(3'd1, 8'hF5);
        read_check(3'd1, "R3");

        // R5 empty select targets endpoint 0
        bus_write(3'd1, 8'h00);
        bus_write(3'd2, 8'h3C);
        read_check(3'd4, "R5");
        drain(0, "R5");

        // R4 priority: bits B and C set -> C (index 3)
        bus_write(3'd1, 8'h06);
        bus_write(3'd2, 8'hA1);
        read_check(3'd4, "R4");
        check(drain_valid == 5'b01000, "R4", drain_valid, 5'b01000);
        bus_write(3'd1, 8'h0F);
        read_check(3'd4, "R4");

        // R7 disabled window write
        bus_write(3'd0, 8'h01);
        bus_write(3'd2, 8'h77);
        read_check(3'd4, "R7");
        check(drain_valid == 5'b01000, "R7", drain_valid, 5'b01000);
        drain(3, "R7");
        bus_write(3'd0, 8'h02);

        // R8 / R6 fill endpoint A, overflow, clear on read, drain order
        bus_write(3'd1, 8'h01);
        for (int i = 0; i < DEPTH; i++) bus_write(3'd2, 8'(8'h10 + i));
        read_check(3'd3, "R8");
        read_check(3'd4, "R9");
        bus_write(3'd2, 8'hEE);
        read_check(3'd3, "R8");
        read_check(3'd3, "R8");
        for (int i = 0; i < DEPTH; i++) drain(1, "R6");
        read_check(3'd4, "R9");

        // R9 update one cycle after a drain
        bus_write(3'd2, 8'h55);
        read_check(3'd4, "R9");
        drain(1, "R9");
        read_check(3'd4, "R9");

        // R10 window and unused offsets read 0, data holds
        read_check(3'd2, "R10");
        read_check(3'd5, "R10");
        read_check(3'd7, "R10");
        bus_read(3'd0, v);
        repeat (4) @(negedge clk);
        check(bus_rdata == v, "R10", bus_rdata, v);

        // seeded random mix
        void'($urandom(32'd4242));
        for (int n = 0; n < 1500; n++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: bus_write(3'd0, 8'($urandom_range(0, 255)) | ($urandom_range(0, 5) != 0 ? 8'h02 : 8'h00));
                1: bus_write(3'd1, 8'($urandom_range(0, 255)));
                2, 3, 4, 5: bus_write(3'd2, 8'($urandom_range(0, 255)));
                6: read_check(3'($urandom_range(0, 7)), "R6");
                7: read_check(3'd4, "R9");
                8: read_check(3'd3, "R8");
                default: drain($urandom_range(0, 4), "R6");
            endcase
        end
        for (int e = 0; e < NEP; e++) begin
            while (mc[e] > 0) drain(e, "R6");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule